// File: doc/BRIEF.md
# Power-Up Strap Latch With Fuse Override

This block reads two mode-strap pads exactly once, after power-on reset ends, and keeps what it read as the chip's mode controls until the next power-on reset. One strap turns off test mode and the other turns off serial download mode. Both are active low and both pads are pulled up, so an unconnected pad selects normal operation. A one-time-programmable fuse bit can forbid download mode whatever level the download strap had.

After reset is released, the block waits a fixed settling window of `SETTLE_CYCLES` clock edges. On the last edge of that window it latches both pad levels and the fuse bit, then raises a valid flag. Until the flag rises, both mode enables stay at their inactive value. Once the flag is set, later pad activity is ignored, including pad activity when a strap pad also serves as a wake source. A read-only status word shows the raw latched bits for software.

Top module: `strap_capture`

## Requirements
- R1: After `por_rst` is released, `strap_valid` stays 0 after the first `SETTLE_CYCLES-1` (default 3) rising edges and becomes 1 after edge `SETTLE_CYCLES` (default 4). It then stays 1 until `por_rst` is asserted again.
- R2: While `strap_valid` is 0, `test_mode_en` and `dl_mode_en` are both 0.
- R3: When `strap_valid` is 1, `test_mode_en` is 1 exactly when `pad_test_dis_n` was 0 at the capture edge.
- R4: When `strap_valid` is 1 and the latched fuse bit is 0, `dl_mode_en` is 1 exactly when `pad_dl_dis_n` was 0 at the capture edge.
- R5: When the fuse bit `otp_dl_block` was 1 at the capture edge, `dl_mode_en` is 0 whatever the download strap level was.
- R6: After capture, changes on `pad_test_dis_n`, `pad_dl_dis_n` or `otp_dl_block` do not change `test_mode_en`, `dl_mode_en` or `strap_status`.
- R7: `strap_status` bit 0 is the latched test strap, bit 1 the latched download strap and bit 2 the latched fuse bit. During reset and before capture it reads 3'b011, which is the pulled-up pad default with no fuse override.
- R8: Only the pad levels at the capture edge count. Levels present on earlier edges of the settling window have no effect.
- R9: Asserting `por_rst` at any time clears `strap_valid` and restarts the settling window. The next capture samples the pads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, active high, synchronous |
| pad_test_dis_n | input | 1 | Test-mode disable strap pad level (0 selects test mode) |
| pad_dl_dis_n | input | 1 | Download disable strap pad level (0 selects download mode) |
| otp_dl_block | input | 1 | Fuse bit; 1 forbids download mode |
| test_mode_en | output | 1 | Test mode enable |
| dl_mode_en | output | 1 | Serial download mode enable |
| strap_valid | output | 1 | Straps have been latched |
| strap_status | output | 3 | Latched raw bits {fuse, download strap, test strap} |

## Verification
A settling counter that is wrong by one edge moves the rise of `strap_valid`, and the mode enables and status word change with it. This shows up on the first power-up as a mismatch on the third or fourth edge after reset. If the capture register is not frozen after capture, the damage appears only when the pads move later. For that reason every power-up is followed by inverting all inputs and checking that the outputs keep their values. A wrong polarity or a missing fuse mask shows in the sweep over all eight pad and fuse combinations, on the first cycle after capture.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Latched strap record; bit order matches the status word
    typedef struct packed {
        logic otp_block;   // bit 2
        logic dl_dis_n;    // bit 1
        logic test_dis_n;  // bit 0
    } strap_rec_t;

    localparam int STATUS_W = $bits(strap_rec_t);

    // Pull-up default: both straps high, no fuse override
    localparam strap_rec_t STRAP_REC_RST = '{otp_block: 1'b0, dl_dis_n: 1'b1, test_dis_n: 1'b1};

    typedef struct packed {
        logic test_en;
        logic dl_en;
    } mode_t;

    function automatic mode_t decode_modes(input strap_rec_t rec, input logic valid);
        mode_t m;
        m.test_en = valid & ~rec.test_dis_n;
        m.dl_en   = valid & ~rec.dl_dis_n & ~rec.otp_block;
        return m;
    endfunction

endpackage

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic capture,
    output logic valid
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign capture = ~rst & ~valid & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else if (!valid) begin
            if (cnt == LAST) valid <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end
    end

    // R1
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);
    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R1
    valid_after_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(cnt) == LAST);
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !valid);
endmodule

// File: rtl/strap_capture_reg.sv
module strap_capture_reg
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic       valid,
    input  strap_rec_t pads,
    output strap_rec_t latched
);
    always_ff @(posedge clk) begin
        if (rst)          latched <= STRAP_REC_RST;
        else if (capture) latched <= pads;
    end

    // R6
    frozen_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> $stable(latched));
    // R7
    default_before_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !valid && !capture |=> latched == STRAP_REC_RST);
endmodule

// File: rtl/strap_mode_decode.sv
module strap_mode_decode
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strap_rec_t latched,
    input  logic       valid,
    output mode_t      modes
);
    always_comb modes = decode_modes(latched, valid);

    // R2
    inactive_until_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !modes.test_en && !modes.dl_en);
    // R5
    fuse_masks_download_chk: assert property (@(posedge clk) disable iff (rst)
        latched.otp_block |-> !modes.dl_en);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                pad_test_dis_n,
    input  logic                pad_dl_dis_n,
    input  logic                otp_dl_block,
    output logic                test_mode_en,
    output logic                dl_mode_en,
    output logic                strap_valid,
    output logic [STATUS_W-1:0] strap_status
);
    logic       capture;
    logic       valid;
    strap_rec_t pads;
    strap_rec_t latched;
    mode_t      modes;

    assign pads = '{otp_block: otp_dl_block, dl_dis_n: pad_dl_dis_n, test_dis_n: pad_test_dis_n};

    strap_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (por_rst),
        .capture (capture),
        .valid   (valid)
    );

    strap_capture_reg u_cap (
        .clk     (clk),
        .rst     (por_rst),
        .capture (capture),
        .valid   (valid),
        .pads    (pads),
        .latched (latched)
    );

    strap_mode_decode u_dec (
        .clk     (clk),
        .rst     (por_rst),
        .latched (latched),
        .valid   (valid),
        .modes   (modes)
    );

    assign test_mode_en = modes.test_en;
    assign dl_mode_en   = modes.dl_en;
    assign strap_valid  = valid;
    assign strap_status = latched;

    // R6
    outputs_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        strap_valid |=> $stable({test_mode_en, dl_mode_en, strap_status}));
endmodule

// File: tb/strap_capture_test.sv
`timescale 1ns/1ps
module strap_capture_test;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic       pad_test_dis_n = 1'b1;
    logic       pad_dl_dis_n = 1'b1;
    logic       otp_dl_block = 1'b0;
    logic       test_mode_en;
    logic       dl_mode_en;
    logic       strap_valid;
    logic [2:0] strap_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strap_capture #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk            (clk),
        .por_rst        (por_rst),
        .pad_test_dis_n (pad_test_dis_n),
        .pad_dl_dis_n   (pad_dl_dis_n),
        .otp_dl_block   (otp_dl_block),
        .test_mode_en   (test_mode_en),
        .dl_mode_en     (dl_mode_en),
        .strap_valid    (strap_valid),
        .strap_status   (strap_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pads(input logic t, input logic d, input logic o);
        pad_test_dis_n = t;
        pad_dl_dis_n   = d;
        otp_dl_block   = o;
    endtask

    // Called at a negedge; reset for two edges, then release at a negedge
    task automatic pulse_reset();
        por_rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 valid in reset", strap_valid, 0);
        chk("R7 status in reset", strap_status, 3);
        por_rst = 1'b0;
    endtask

    // Checks the settling window after release; ends after the capture edge
    task automatic check_window();
        for (int k = 1; k < SETTLE; k++) begin
            @(negedge clk);
            chk("R1 valid during window", strap_valid, 0);
            chk("R2 modes off during window", {test_mode_en, dl_mode_en}, 0);
            chk("R7 status before capture", strap_status, 3);
        end
        @(negedge clk);
        chk("R1 valid after window", strap_valid, 1);
    endtask

    initial begin
        @(negedge clk);
        pulse_reset();
        check_window();

        // Exhaustive sweep over test strap, download strap and fuse bit
        for (int v = 0; v < 8; v++) begin
            logic t, d, o;
            int exp_status;
            t = v[0]; d = v[1]; o = v[2];
            exp_status = v;
            set_pads(t, d, o);
            pulse_reset();
            check_window();
            chk("R3 test mode", test_mode_en, int'(!t));
            if (o) chk("R5 fuse blocks download", dl_mode_en, 0);
            else   chk("R4 download mode", dl_mode_en, int'(!d));
            chk("R7 status", strap_status, exp_status);
            // Invert everything after capture (wake-style pad activity)
            set_pads(!t, !d, !o);
            repeat (3) @(negedge clk);
            chk("R6 test mode held", test_mode_en, int'(!t));
            chk("R6 download held", dl_mode_en, int'(!d && !o));
            chk("R6 status held", strap_status, exp_status);
            chk("R1 valid held", strap_valid, 1);
        end

        // R8: low pads during early window edges, high at the capture edge
        set_pads(1'b0, 1'b0, 1'b0);
        pulse_reset();
        for (int k = 1; k < SETTLE; k++) @(negedge clk);
        set_pads(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 valid", strap_valid, 1);
        chk("R8 early levels ignored", {test_mode_en, dl_mode_en}, 0);
        chk("R8 status", strap_status, 3);

        // R8: high pads early, low at the capture edge
        set_pads(1'b1, 1'b1, 1'b0);
        pulse_reset();
        for (int k = 1; k < SETTLE; k++) @(negedge clk);
        set_pads(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 late levels captured", {test_mode_en, dl_mode_en}, 3);

        // R9: reset reasserted mid-window restarts the count
        set_pads(1'b0, 1'b1, 1'b0);
        pulse_reset();
        repeat (2) @(negedge clk);
        pulse_reset();
        check_window();
        chk("R9 recapture test mode", test_mode_en, 1);
        chk("R9 recapture download", dl_mode_en, 0);

        // R9: reset while valid clears outputs
        por_rst = 1'b1;
        @(negedge clk);
        chk("R9 valid cleared", strap_valid, 0);
        chk("R9 modes cleared", {test_mode_en, dl_mode_en}, 0);
        por_rst = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule